// File: doc/BRIEF.md
# Mode-Switched Serial Configuration Port for a 16-Channel Output Driver

This block takes the serial configuration stream of a 16-channel constant-current driver and turns it into two parallel holding registers: one enable bit per channel, and one 7-bit current-trim word per channel. A mode pin selects one of two shift paths. With the pin low, a 16-bit enable path is active. With the pin high, a 112-bit trim path is active, holding sixteen 7-bit words. Data on the serial input enters the active path on each rising serial clock, most significant bit first. A rising edge on the latch pin copies the active path into its holding register.

In enable mode, the falling edge of the latch pin overwrites the enable path with the per-channel open-load status. The host then reads those bits back on the serial output while it shifts in the next enable word. The serial output always carries the last stage of the active path, so several devices can be daisy-chained by wiring each serial output to the next device's serial input. The external pins are asynchronous to the block's clock. Each one passes through a two-flop synchronizer, and edges are detected from the synchronized samples.

Top module: `ledcfg_serial_port`

## Requirements
- R1: After reset, `chan_on` and `dot_corr` are all zero, and `sdo` is 0 because both shift paths are cleared.
- R2: With `path_sel` low, each rising `sck` shifts `sdi` into the LSB of the 16-bit enable path. On a rising `latch`, `chan_on` takes the path contents. Bit n is channel n, and the first bit shifted lands in bit 15.
- R3: With `path_sel` high, each rising `sck` shifts `sdi` into the 112-bit trim path. On a rising `latch`, `dot_corr` takes the contents. Channel n's word is bits 7n+6..7n, so channel 15 is 111..105 and channel 0 is 6..0, each word MSB first.
- R4: A rising `latch` updates only the holding register that belongs to the current mode. The other holding register keeps its value.
- R5: A falling `latch` with `path_sel` low loads the enable path with `open_flags`, bit n for channel n. The next 16 `sck` rises present these bits on `sdo`, bit 15 first. A falling `latch` takes priority over a coincident `sck` rise.
- R6: A falling `latch` with `path_sel` high leaves the trim path unchanged.
- R7: `sdo` shows the last stage of the active path: bit 15 of the enable path, or bit 111 of the trim path. A bit shifted in therefore leaves on `sdo` one path length later.
- R8: Changing `path_sel` selects the other path from the next `sck` edge onward. The path that is left keeps its contents, and a partly shifted word can be finished after switching back.
- R9: Activity on `sck` alone never changes `chan_on` or `dot_corr`.
- R10: A holding register shows its new value after the third rising system clock edge that follows the `latch` rise, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Serial data input (asynchronous) |
| sck | input | 1 | Serial shift clock (asynchronous) |
| latch | input | 1 | Latch strobe: rise copies the path, fall reloads status (asynchronous) |
| path_sel | input | 1 | 0 selects the enable path, 1 selects the trim path |
| open_flags | input | 16 | Per-channel open-load status, bit n for channel n |
| sdo | output | 1 | Serial data output, last stage of the active path |
| chan_on | output | 16 | Channel enable holding register |
| dot_corr | output | 112 | Per-channel 7-bit current-trim holding register |

## Verification
Any pin change reaches the edge detector after two synchronizer stages. A path shift or status reload therefore happens on the third system clock edge after the pin edge, and `sdo` follows on the fourth. The bench keeps each serial pin level for at least four system clocks and samples only after that wait, on falling clock edges. For the latch-to-holding-register latency, the bench counts rising edges after raising `latch`. It checks that the old value is still present after the second edge and the new value after the third.

// File: rtl/ledcfg_pkg.sv
package ledcfg_pkg;
  localparam int unsigned CH_DEF   = 16;
  localparam int unsigned TRIM_DEF = 7;
  localparam int unsigned SYNC_DEF = 2;

  // asynchronous pin bundle, synchronized as one vector
  typedef struct packed {
    logic sel;
    logic lat;
    logic sck;
    logic sdi;
  } pins_t;

  // single-cycle strobes derived from synchronized samples
  typedef struct packed {
    logic sck_rise;
    logic lat_rise;
    logic lat_fall;
  } evt_t;
endpackage

// File: rtl/ledcfg_sync.sv
module ledcfg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) st[i] <= '0;
          else     st[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) st[i] <= '0;
          else     st[i] <= st[i-1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/ledcfg_edge.sv
module ledcfg_edge (
  input  logic clk,
  input  logic rst,
  input  logic sck_s,
  input  logic lat_s,
  output logic sck_rise,
  output logic lat_rise,
  output logic lat_fall
);
  logic sck_d, lat_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      lat_d <= 1'b0;
    end else begin
      sck_d <= sck_s;
      lat_d <= lat_s;
    end
  end

  assign sck_rise = sck_s & ~sck_d;
  assign lat_rise = lat_s & ~lat_d;
  assign lat_fall = ~lat_s & lat_d;
endmodule

// File: rtl/ledcfg_shift.sv
module ledcfg_shift #(
  parameter int unsigned CH   = 16,
  parameter int unsigned TRIM = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel,
  input  logic                 sdi,
  input  logic                 sck_rise,
  input  logic                 lat_fall,
  input  logic [CH-1:0]        status,
  output logic [CH-1:0]        en_path,
  output logic [CH*TRIM-1:0]   tr_path
);
  localparam int unsigned TL = CH * TRIM;

  // enable path: active when sel is low; status reload wins over a shift
  always_ff @(posedge clk) begin
    if (rst) begin
      en_path <= '0;
    end else if (!sel) begin
      if (lat_fall)      en_path <= status;
      else if (sck_rise) en_path <= {en_path[CH-2:0], sdi};
    end
  end

  // trim path: active when sel is high; latch fall does not touch it
  always_ff @(posedge clk) begin
    if (rst) begin
      tr_path <= '0;
    end else if (sel && sck_rise) begin
      tr_path <= {tr_path[TL-2:0], sdi};
    end
  end

  AST_TRIM_IDLE: assert property (@(posedge clk) disable iff (rst)
    !sel |=> $stable(tr_path)); // R8
  AST_STATUS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (lat_fall && !sel) |=> (en_path == $past(status))); // R5
  AST_TRIM_FALL_KEEP: assert property (@(posedge clk) disable iff (rst)
    (lat_fall && sel && !sck_rise) |=> $stable(tr_path)); // R6
  AST_EN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (sck_rise && !sel && !lat_fall) |=> (en_path[CH-1:1] == $past(en_path[CH-2:0]))); // R2
endmodule

// File: rtl/ledcfg_hold.sv
module ledcfg_hold #(
  parameter int unsigned CH   = 16,
  parameter int unsigned TRIM = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic               lat_rise,
  input  logic [CH-1:0]      en_path,
  input  logic [CH*TRIM-1:0] tr_path,
  output logic [CH-1:0]      en_q,
  output logic [CH*TRIM-1:0] tr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      tr_q <= '0;
    end else if (lat_rise) begin
      if (sel) tr_q <= tr_path;
      else     en_q <= en_path;
    end
  end

  AST_EN_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(lat_rise && !sel) |=> $stable(en_q)); // R9
  AST_TRIM_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(lat_rise && sel) |=> $stable(tr_q)); // R4
  AST_EN_LOAD: assert property (@(posedge clk) disable iff (rst)
    (lat_rise && !sel) |=> (en_q == $past(en_path))); // R2
  AST_TRIM_LOAD: assert property (@(posedge clk) disable iff (rst)
    (lat_rise && sel) |=> (tr_q == $past(tr_path))); // R3
endmodule

// File: rtl/ledcfg_serial_port.sv
module ledcfg_serial_port
  import ledcfg_pkg::*;
#(
  parameter int unsigned CH     = CH_DEF,
  parameter int unsigned TRIM   = TRIM_DEF,
  parameter int unsigned STAGES = SYNC_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sdi,
  input  logic                 sck,
  input  logic                 latch,
  input  logic                 path_sel,
  input  logic [CH-1:0]        open_flags,
  output logic                 sdo,
  output logic [CH-1:0]        chan_on,
  output logic [CH*TRIM-1:0]   dot_corr
);
  localparam int unsigned TL = CH * TRIM;
  localparam int unsigned PW = $bits(pins_t);

  pins_t            pins_raw, pins_s;
  evt_t             evt;
  logic [CH-1:0]    status_s;
  logic [CH-1:0]    en_path;
  logic [TL-1:0]    tr_path;

  assign pins_raw = {path_sel, latch, sck, sdi};

  ledcfg_sync #(.W(PW), .STAGES(STAGES)) u_pin_sync (
    .clk (clk), .rst (rst), .d (pins_raw), .q (pins_s)
  );

  ledcfg_sync #(.W(CH), .STAGES(STAGES)) u_stat_sync (
    .clk (clk), .rst (rst), .d (open_flags), .q (status_s)
  );

  ledcfg_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .sck_s    (pins_s.sck),
    .lat_s    (pins_s.lat),
    .sck_rise (evt.sck_rise),
    .lat_rise (evt.lat_rise),
    .lat_fall (evt.lat_fall)
  );

  ledcfg_shift #(.CH(CH), .TRIM(TRIM)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .sel      (pins_s.sel),
    .sdi      (pins_s.sdi),
    .sck_rise (evt.sck_rise),
    .lat_fall (evt.lat_fall),
    .status   (status_s),
    .en_path  (en_path),
    .tr_path  (tr_path)
  );

  ledcfg_hold #(.CH(CH), .TRIM(TRIM)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .sel      (pins_s.sel),
    .lat_rise (evt.lat_rise),
    .en_path  (en_path),
    .tr_path  (tr_path),
    .en_q     (chan_on),
    .tr_q     (dot_corr)
  );

  // registered serial output: last stage of whichever path is active
  always_ff @(posedge clk) begin
    if (rst) sdo <= 1'b0;
    else     sdo <= pins_s.sel ? tr_path[TL-1] : en_path[CH-1];
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (chan_on == '0 && dot_corr == '0 && !sdo)); // R1
endmodule

// File: tb/ledcfg_serial_port_tb.sv
module ledcfg_serial_port_tb;
  localparam int CH = 16;
  localparam int TRIM = 7;
  localparam int TL = CH * TRIM;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sdi = 1'b0, sck = 1'b0, latch = 1'b0, path_sel = 1'b0;
  logic [CH-1:0] open_flags = '0;
  logic sdo;
  logic [CH-1:0] chan_on;
  logic [TL-1:0] dot_corr;

  int checks = 0;
  int errors = 0;
  logic [CH-1:0] e_on = '0;
  logic [TL-1:0] e_dc = '0;

  always #2 clk = ~clk;

  ledcfg_serial_port u_dut (
    .clk(clk), .rst(rst), .sdi(sdi), .sck(sck), .latch(latch),
    .path_sel(path_sel), .open_flags(open_flags), .sdo(sdo),
    .chan_on(chan_on), .dot_corr(dot_corr)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic seen);
    seen = sdo;
    sdi = b;
    waitn(2);
    sck = 1'b1;
    waitn(4);
    sck = 1'b0;
    waitn(4);
  endtask

  task automatic send_en(input logic [CH-1:0] w, output logic [CH-1:0] cap);
    for (int i = CH - 1; i >= 0; i--) send_bit(w[i], cap[i]);
  endtask

  task automatic send_tr(input logic [TL-1:0] v, output logic [TL-1:0] cap);
    for (int i = TL - 1; i >= 0; i--) send_bit(v[i], cap[i]);
  endtask

  task automatic pulse_latch();
    latch = 1'b1;
    waitn(4);
    latch = 1'b0;
    waitn(4);
  endtask

  task automatic set_sel(input logic m);
    path_sel = m;
    waitn(4);
  endtask

  function automatic logic [TL-1:0] pack_trim(input logic [6:0] w15, input logic [6:0] w0,
                                               input logic [6:0] fill);
    logic [TL-1:0] v;
    for (int n = 0; n < CH; n++) v[7*n +: 7] = fill;
    v[111:105] = w15;
    v[6:0] = w0;
    return v;
  endfunction

  function automatic logic [TL-1:0] rand_trim();
    logic [TL-1:0] v;
    for (int n = 0; n < CH; n++) v[7*n +: 7] = 7'($urandom);
    return v;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [CH-1:0] cap16, w, s, w2;
    logic [TL-1:0] cap112, v, v3;
    logic seen;
    void'($urandom(32'h5eed_1234));
    waitn(6);
    rst = 1'b0;
    waitn(3);
    // R1 reset state
    chk("R1 chan_on", chan_on, 0);
    chk("R1 dot_corr", dot_corr, 0);
    chk("R1 sdo", sdo, 0);

    // enable path: directed and random words
    for (int k = 0; k < 6; k++) begin
      w = (k == 0) ? 16'hFFFF : (k == 1) ? 16'h8001 : 16'($urandom);
      send_en(w, cap16);
      chk("R9 chan_on unchanged by sck", chan_on, e_on);
      pulse_latch();
      e_on = w;
      chk("R2 chan_on after latch", chan_on, e_on);
      chk("R4 dot_corr kept in enable mode", dot_corr, e_dc);
    end

    // trim path
    set_sel(1'b1);
    for (int k = 0; k < 4; k++) begin
      v = (k == 0) ? pack_trim(7'h7F, 7'h7F, 7'h7F) :
          (k == 1) ? pack_trim(7'h7F, 7'h01, 7'h00) : rand_trim();
      send_tr(v, cap112);
      chk("R9 dot_corr unchanged by sck", dot_corr, e_dc);
      if (k > 0) chk("R6 R7 trim path passes previous frame on sdo", cap112, e_dc);
      pulse_latch();
      e_dc = v;
      chk("R3 dot_corr after latch", dot_corr, e_dc);
      chk("R4 chan_on kept in trim mode", chan_on, e_on);
      if (k == 1) begin
        chk("R3 channel 15 word at 111..105", dot_corr[111:105], 7'h7F);
        chk("R3 channel 0 word at 6..0", dot_corr[6:0], 7'h01);
        chk("R3 channel 1 word zero", dot_corr[13:7], 0);
      end
    end

    // status readback in enable mode
    set_sel(1'b0);
    for (int k = 0; k < 4; k++) begin
      s = (k == 0) ? 16'hA5C3 : 16'($urandom);
      open_flags = s;
      waitn(4);
      w = 16'($urandom);
      send_en(w, cap16);
      pulse_latch();
      e_on = w;
      chk("R2 chan_on before readback", chan_on, e_on);
      w2 = ~w;
      send_en(w2, cap16);
      chk("R5 open status shifted out on sdo", cap16, s);
      pulse_latch();
      e_on = w2;
      chk("R2 chan_on after readback", chan_on, e_on);
    end

    // mode switch in the middle of an enable word
    w = 16'($urandom);
    for (int i = CH - 1; i >= 8; i--) send_bit(w[i], seen);
    set_sel(1'b1);
    chk("R7 sdo shows trim path msb", sdo, e_dc[TL-1]);
    v3 = rand_trim();
    send_tr(v3, cap112);
    chk("R8 trim path kept across enable activity", cap112, e_dc);
    set_sel(1'b0);
    for (int i = 7; i >= 0; i--) send_bit(w[i], seen);
    pulse_latch();
    e_on = w;
    chk("R8 split enable word latched", chan_on, e_on);
    chk("R4 dot_corr kept", dot_corr, e_dc);
    set_sel(1'b1);
    pulse_latch();
    e_dc = v3;
    chk("R8 trim frame latched after switch", dot_corr, e_dc);

    // latch latency
    set_sel(1'b0);
    w2 = ~e_on;
    send_en(w2, cap16);
    @(negedge clk);
    latch = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R10 old value after two edges", chan_on, e_on);
    @(posedge clk);
    #1;
    e_on = w2;
    chk("R10 new value after third edge", chan_on, e_on);
    waitn(3);
    latch = 1'b0;
    waitn(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule